// File: doc/BRIEF.md
# Locality Ownership Gate for a Trusted Module Register Interface

This block decides, access by access, whether a decoded register access to a trusted-module interface is carried out or silently dropped. It sits between the bus target, which has already turned the bus cycle into a locality number, a register class and a direction, and the interface registers. The block owns one piece of state: which locality, if any, currently holds the interface. Each access is classified by the relation of its locality to that owner: it is the owner, some other locality owns the interface, or the interface is free. The register class and the direction then select the rights that apply.

The verdict is combinational from the current owner state and the present inputs. The bus target can therefore answer with a completion handshake or stay silent in the same cycle. Accepted writes drive a register write enable. A write to the interrupt-status class instead drives an interrupt-clear pulse. Ownership changes on explicit request and release writes to the access-control register, on the hash-start write, which seizes the interface for locality 4, and on the hash-end write, which frees it.

Top module: `locality_arbiter`

## Requirements
- R1: After reset, no locality owns the interface (`owner_valid` is 0).
- R2: For every cycle with `acc_valid` high, exactly one of `acc_accept` and `acc_abort` is high. With `acc_valid` low, both are low. Any locality above 4 is always aborted. The class codes on `acc_class` are as follows. Codes 11 to 15 always abort.

  | Code | Class |
  |---|---|
  | 0 | status |
  | 1 | interrupt enable |
  | 2 | interrupt vector |
  | 3 | interrupt status |
  | 4 | interrupt capability |
  | 5 | access control |
  | 6 | data FIFO |
  | 7 | configuration |
  | 8 | hash start |
  | 9 | hash data |
  | 10 | hash end |

- R3: The status class is readable and writable only by the owning locality. Every other access to it aborts.
- R4: The interrupt-enable, interrupt-vector and configuration classes are readable from any valid locality, whether or not it owns the interface. They are writable only by the owner.
- R5: An interrupt-status write from the owner is accepted. It produces a one-cycle `int_clear` and no `reg_wr_en`. The same write from any non-owner aborts. Reads of this class are accepted from any valid locality.
- R6: Any write to the interrupt-capability class aborts. Reads of it are accepted from any valid locality.
- R7: The access-control class is readable and writable from any valid locality. A write with `req_use` set grants ownership to the writer only when the interface is free. A write with `req_release` set frees the interface only when the writer is the owner.
- R8: A data-FIFO read is accepted only from the owner while `data_avail` is 1. A data-FIFO write is accepted only from the owner.
- R9: A hash-start write is accepted only while the interface is free, and it makes locality 4 the owner in the next cycle.
- R10: Hash-data and hash-end writes are accepted only from the owner. An accepted hash-end write frees the interface in the next cycle. Every read of the three hash classes aborts.
- R11: `reg_wr_en` is high exactly for accepted writes other than the interrupt-status class. The owner state changes only after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A decoded access is present this cycle |
| acc_loc | input | 3 | Locality of the access |
| acc_class | input | 4 | Register class code (see R2) |
| acc_write | input | 1 | 1 = write, 0 = read |
| data_avail | input | 1 | Read data is waiting in the FIFO |
| req_use | input | 1 | Access-control write requests ownership |
| req_release | input | 1 | Access-control write gives up ownership |
| acc_accept | output | 1 | Access is carried out |
| acc_abort | output | 1 | Access is dropped |
| reg_wr_en | output | 1 | Write enable toward the addressed register |
| int_clear | output | 1 | Clears the pending interrupt |
| owner_valid | output | 1 | Some locality owns the interface |
| owner_loc | output | 3 | Owning locality (meaningful when owner_valid) |

## Verification
The assertions assume that `acc_loc`, `acc_class` and the direction are stable and known for the whole cycle in which `acc_valid` is high. They also assume that `req_use` and `req_release` only carry meaning alongside an access-control write. The bench drives every input at the falling edge and holds it for a full cycle. It raises the request and release bits only on access-control writes, with one deliberate case that sets both. It also uses out-of-range locality values to reach the always-abort path without leaving known values.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_STATUS     = 4'd0,
    CLS_IRQ_EN     = 4'd1,
    CLS_IRQ_VEC    = 4'd2,
    CLS_IRQ_STAT   = 4'd3,
    CLS_IRQ_CAP    = 4'd4,
    CLS_ACCESS     = 4'd5,
    CLS_FIFO       = 4'd6,
    CLS_CONFIG     = 4'd7,
    CLS_HASH_START = 4'd8,
    CLS_HASH_DATA  = 4'd9,
    CLS_HASH_END   = 4'd10
  } reg_cls_e;

  // How the requesting locality stands against the current owner
  typedef enum logic [1:0] {
    REL_FREE  = 2'd0,
    REL_OWNER = 2'd1,
    REL_OTHER = 2'd2,
    REL_BAD   = 2'd3
  } loc_rel_e;

endpackage

// File: rtl/loc_relation.sv
module loc_relation
  import loc_arb_pkg::*;
#(
  parameter int LOC_W   = 3,
  parameter int NUM_LOC = 5
) (
  input  logic [LOC_W-1:0] loc,
  input  logic             owner_valid,
  input  logic [LOC_W-1:0] owner_loc,
  output loc_rel_e         rel
);

  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(NUM_LOC - 1);

  always_comb begin
    if (loc > LAST_LOC)          rel = REL_BAD;
    else if (!owner_valid)       rel = REL_FREE;
    else if (loc == owner_loc)   rel = REL_OWNER;
    else                         rel = REL_OTHER;
  end

endmodule

// File: rtl/loc_rights.sv
module loc_rights
  import loc_arb_pkg::*;
#(
  parameter int CW = CLS_W
) (
  input  loc_rel_e        rel,
  input  logic [CW-1:0]   cls,
  input  logic            write,
  input  logic            data_avail,
  output logic            allow,
  output logic            wr_en,
  output logic            clr
);

  logic is_owner;
  logic is_known;

  assign is_owner = (rel == REL_OWNER);
  assign is_known = (rel != REL_BAD);

  always_comb begin
    allow = 1'b0;
    if (is_known) begin
      case (reg_cls_e'(cls))
        CLS_STATUS:                          allow = is_owner;
        CLS_IRQ_EN, CLS_IRQ_VEC, CLS_CONFIG: allow = write ? is_owner : 1'b1;
        CLS_IRQ_STAT:                        allow = write ? is_owner : 1'b1;
        CLS_IRQ_CAP:                         allow = !write;
        CLS_ACCESS:                          allow = 1'b1;
        CLS_FIFO:                            allow = is_owner && (write || data_avail);
        CLS_HASH_START:                      allow = write && (rel == REL_FREE);
        CLS_HASH_DATA, CLS_HASH_END:         allow = write && is_owner;
        default:                             allow = 1'b0;
      endcase
    end
  end

  always_comb begin
    clr   = allow && write && (cls == CLS_IRQ_STAT);
    wr_en = allow && write && (cls != CLS_IRQ_STAT);
  end

endmodule

// File: rtl/loc_owner_reg.sv
module loc_owner_reg
  import loc_arb_pkg::*;
#(
  parameter int LOC_W    = 3,
  parameter int HASH_LOC = 4,
  parameter int CW       = CLS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_done,
  input  logic [CW-1:0]    cls,
  input  loc_rel_e         rel,
  input  logic [LOC_W-1:0] loc,
  input  logic             req_use,
  input  logic             req_release,
  output logic             owner_valid,
  output logic [LOC_W-1:0] owner_loc
);

  localparam logic [LOC_W-1:0] SEIZE_LOC = LOC_W'(HASH_LOC);

  logic             valid_d;
  logic [LOC_W-1:0] loc_d;
  logic             upd_en;

  always_comb begin
    valid_d = owner_valid;
    loc_d   = owner_loc;
    if (wr_done) begin
      case (reg_cls_e'(cls))
        CLS_HASH_START: begin
          valid_d = 1'b1;
          loc_d   = SEIZE_LOC;
        end
        CLS_HASH_END: valid_d = 1'b0;
        CLS_ACCESS: begin
          if (req_release && rel == REL_OWNER) begin
            valid_d = 1'b0;
          end else if (req_use && rel == REL_FREE) begin
            valid_d = 1'b1;
            loc_d   = loc;
          end
        end
        default: ;
      endcase
    end
  end

  assign upd_en = wr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_valid <= 1'b0;
      owner_loc   <= '0;
    end else if (upd_en) begin
      owner_valid <= valid_d;
      owner_loc   <= loc_d;
    end
  end

endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
  import loc_arb_pkg::*;
#(
  parameter int LOC_W    = 3,
  parameter int NUM_LOC  = 5,
  parameter int HASH_LOC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [LOC_W-1:0] acc_loc,
  input  logic [CLS_W-1:0] acc_class,
  input  logic             acc_write,
  input  logic             data_avail,
  input  logic             req_use,
  input  logic             req_release,
  output logic             acc_accept,
  output logic             acc_abort,
  output logic             reg_wr_en,
  output logic             int_clear,
  output logic             owner_valid,
  output logic [LOC_W-1:0] owner_loc
);

  loc_rel_e rel;
  logic     allow;
  logic     rw_en;
  logic     rclr;
  logic     wr_done;

  loc_relation #(.LOC_W(LOC_W), .NUM_LOC(NUM_LOC)) u_rel (
    .loc         (acc_loc),
    .owner_valid (owner_valid),
    .owner_loc   (owner_loc),
    .rel         (rel)
  );

  loc_rights #(.CW(CLS_W)) u_rights (
    .rel        (rel),
    .cls        (acc_class),
    .write      (acc_write),
    .data_avail (data_avail),
    .allow      (allow),
    .wr_en      (rw_en),
    .clr        (rclr)
  );

  assign acc_accept = acc_valid && allow;
  assign acc_abort  = acc_valid && !allow;
  assign reg_wr_en  = acc_valid && rw_en;
  assign int_clear  = acc_valid && rclr;
  assign wr_done    = acc_accept && acc_write;

  loc_owner_reg #(.LOC_W(LOC_W), .HASH_LOC(HASH_LOC), .CW(CLS_W)) u_owner (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_done     (wr_done),
    .cls         (acc_class),
    .rel         (rel),
    .loc         (acc_loc),
    .req_use     (req_use),
    .req_release (req_release),
    .owner_valid (owner_valid),
    .owner_loc   (owner_loc)
  );

endmodule

// File: rtl/loc_arb_checker.sv
module loc_arb_checker
  import loc_arb_pkg::*;
#(
  parameter int LOC_W    = 3,
  parameter int NUM_LOC  = 5,
  parameter int HASH_LOC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [LOC_W-1:0] acc_loc,
  input logic [CLS_W-1:0] acc_class,
  input logic             acc_write,
  input logic             acc_accept,
  input logic             acc_abort,
  input logic             reg_wr_en,
  input logic             int_clear,
  input logic             owner_valid,
  input logic [LOC_W-1:0] owner_loc
);

  localparam logic [LOC_W-1:0] LAST_LOC  = LOC_W'(NUM_LOC - 1);
  localparam logic [LOC_W-1:0] SEIZE_LOC = LOC_W'(HASH_LOC);

  p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $countones({acc_accept, acc_abort}) == 1);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_accept && !acc_abort && !reg_wr_en && !int_clear);

  p_bad_loc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_loc > LAST_LOC) |-> acc_abort);

  p_status_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_accept && acc_class == CLS_STATUS) |-> owner_valid && acc_loc == owner_loc);

  p_clear_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_clear |-> owner_valid && acc_loc == owner_loc && !reg_wr_en);

  p_cap_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_class == CLS_IRQ_CAP) |-> acc_abort);

  p_hash_seize_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_accept && acc_write && acc_class == CLS_HASH_START)
      |=> owner_valid && owner_loc == SEIZE_LOC);

  p_hash_start_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_accept && acc_class == CLS_HASH_START) |-> !owner_valid);

  p_hash_end_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_accept && acc_write && acc_class == CLS_HASH_END) |=> !owner_valid);

  p_wren_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> acc_accept && acc_write);

  p_owner_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_accept && acc_write) |=> $stable({owner_valid, owner_loc}));

endmodule

bind locality_arbiter loc_arb_checker #(
  .LOC_W(LOC_W), .NUM_LOC(NUM_LOC), .HASH_LOC(HASH_LOC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_loc     (acc_loc),
  .acc_class   (acc_class),
  .acc_write   (acc_write),
  .acc_accept  (acc_accept),
  .acc_abort   (acc_abort),
  .reg_wr_en   (reg_wr_en),
  .int_clear   (int_clear),
  .owner_valid (owner_valid),
  .owner_loc   (owner_loc)
);

// File: tb/locality_arbiter_tb.sv
module locality_arbiter_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       acc_valid;
  logic [2:0] acc_loc;
  logic [3:0] acc_class;
  logic       acc_write;
  logic       data_avail;
  logic       req_use;
  logic       req_release;
  logic       acc_accept;
  logic       acc_abort;
  logic       reg_wr_en;
  logic       int_clear;
  logic       owner_valid;
  logic [2:0] owner_loc;

  locality_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_loc(acc_loc),
    .acc_class(acc_class), .acc_write(acc_write), .data_avail(data_avail),
    .req_use(req_use), .req_release(req_release), .acc_accept(acc_accept),
    .acc_abort(acc_abort), .reg_wr_en(reg_wr_en), .int_clear(int_clear),
    .owner_valid(owner_valid), .owner_loc(owner_loc)
  );

  typedef struct {
    logic       vld;
    logic       ok;
    logic       we;
    logic       clr;
    logic       ov;
    logic [2:0] ol;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp  = 0;
  int   n_bad  = 0;
  bit   done   = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Driver: one access per cycle, expected result pushed to the scoreboard
  task automatic acc(input logic v, input logic [2:0] l, input logic [3:0] c,
                     input logic w, input logic da, input logic rq, input logic rl,
                     input logic ok, input logic we, input logic clr,
                     input logic ov, input logic [2:0] ol, input string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = v; acc_loc = l; acc_class = c; acc_write = w;
    data_avail = da; req_use = rq; req_release = rl;
    e.vld = v; e.ok = ok; e.we = we; e.clr = clr; e.ov = ov; e.ol = ol; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input logic ov, input logic [2:0] ol, input string tag);
    acc(1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, ov, ol, tag);
  endtask

  // Monitor: compares a quarter period after each driving edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        logic [5:0] act, want;
        e = exp_q.pop_front();
        act  = {acc_accept, acc_abort, reg_wr_en, int_clear, owner_valid,
                (owner_valid ? 1'b1 : 1'b0)};
        want = {e.vld && e.ok, e.vld && !e.ok, e.we, e.clr, e.ov, e.ov};
        n_cmp++;
        if (act != want || (e.ov && owner_loc != e.ol)) begin
          n_bad++;
          $display("FAIL %s: acc/abt/we/clr/ov=%b loc=%0d expected %b loc=%0d",
                   e.tag, act[5:1], owner_loc, want[5:1], e.ol);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    acc_valid = 0; acc_loc = 0; acc_class = 0; acc_write = 0;
    data_avail = 0; req_use = 0; req_release = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    //   v  loc  cls    w  da rq rl  ok we clr  ov ol
    idle(0, 3'd0, "R1 reset owner");
    acc(1, 3'd0, 4'd0,  0, 0, 0, 0,  0, 0, 0,  0, 3'd0, "R3 status read free");
    acc(1, 3'd0, 4'd1,  0, 0, 0, 0,  1, 0, 0,  0, 3'd0, "R4 irq enable read free");
    acc(1, 3'd0, 4'd1,  1, 0, 0, 0,  0, 0, 0,  0, 3'd0, "R4 irq enable write free");
    acc(1, 3'd0, 4'd8,  0, 0, 0, 0,  0, 0, 0,  0, 3'd0, "R10 hash start read");
    acc(1, 3'd7, 4'd5,  1, 0, 1, 0,  0, 0, 0,  0, 3'd0, "R2 locality 7");
    acc(1, 3'd5, 4'd5,  0, 0, 0, 0,  0, 0, 0,  0, 3'd0, "R2 locality 5");
    acc(1, 3'd0, 4'd12, 0, 0, 0, 0,  0, 0, 0,  0, 3'd0, "R2 unknown class");
    acc(1, 3'd2, 4'd5,  1, 0, 1, 0,  1, 1, 0,  0, 3'd0, "R7 R11 request free");
    acc(1, 3'd1, 4'd5,  1, 0, 1, 0,  1, 1, 0,  1, 3'd2, "R7 request while owned");
    acc(1, 3'd2, 4'd0,  1, 0, 0, 0,  1, 1, 0,  1, 3'd2, "R3 status write owner");
    acc(1, 3'd1, 4'd0,  0, 0, 0, 0,  0, 0, 0,  1, 3'd2, "R3 status read other");
    acc(1, 3'd1, 4'd2,  0, 0, 0, 0,  1, 0, 0,  1, 3'd2, "R4 vector read other");
    acc(1, 3'd1, 4'd7,  1, 0, 0, 0,  0, 0, 0,  1, 3'd2, "R4 config write other");
    acc(1, 3'd2, 4'd7,  1, 0, 0, 0,  1, 1, 0,  1, 3'd2, "R4 config write owner");
    acc(1, 3'd2, 4'd3,  1, 0, 0, 0,  1, 0, 1,  1, 3'd2, "R5 R11 irq clear owner");
    acc(1, 3'd3, 4'd3,  1, 0, 0, 0,  0, 0, 0,  1, 3'd2, "R5 irq clear other");
    acc(1, 3'd3, 4'd3,  0, 0, 0, 0,  1, 0, 0,  1, 3'd2, "R5 irq status read other");
    acc(1, 3'd2, 4'd4,  1, 0, 0, 0,  0, 0, 0,  1, 3'd2, "R6 cap write owner");
    acc(1, 3'd0, 4'd4,  0, 0, 0, 0,  1, 0, 0,  1, 3'd2, "R6 cap read other");
    acc(1, 3'd2, 4'd6,  0, 0, 0, 0,  0, 0, 0,  1, 3'd2, "R8 fifo read no data");
    acc(1, 3'd2, 4'd6,  0, 1, 0, 0,  1, 0, 0,  1, 3'd2, "R8 fifo read data");
    acc(1, 3'd1, 4'd6,  0, 1, 0, 0,  0, 0, 0,  1, 3'd2, "R8 fifo read other");
    acc(1, 3'd2, 4'd6,  1, 0, 0, 0,  1, 1, 0,  1, 3'd2, "R8 fifo write owner");
    acc(1, 3'd1, 4'd6,  1, 0, 0, 0,  0, 0, 0,  1, 3'd2, "R8 fifo write other");
    acc(1, 3'd2, 4'd8,  1, 0, 0, 0,  0, 0, 0,  1, 3'd2, "R9 hash start while owned");
    acc(1, 3'd2, 4'd9,  1, 0, 0, 0,  1, 1, 0,  1, 3'd2, "R10 hash data owner");
    acc(1, 3'd1, 4'd5,  1, 0, 0, 1,  1, 1, 0,  1, 3'd2, "R7 release by other");
    acc(1, 3'd2, 4'd0,  0, 0, 0, 0,  1, 0, 0,  1, 3'd2, "R7 owner kept");
    acc(1, 3'd2, 4'd5,  1, 0, 0, 1,  1, 1, 0,  1, 3'd2, "R7 release by owner");
    acc(1, 3'd2, 4'd0,  0, 0, 0, 0,  0, 0, 0,  0, 3'd0, "R7 released");
    acc(1, 3'd0, 4'd8,  1, 0, 0, 0,  1, 1, 0,  0, 3'd0, "R9 hash start free");
    acc(1, 3'd4, 4'd9,  1, 0, 0, 0,  1, 1, 0,  1, 3'd4, "R9 seized loc 4");
    acc(1, 3'd0, 4'd9,  1, 0, 0, 0,  0, 0, 0,  1, 3'd4, "R10 hash data other");
    acc(1, 3'd4, 4'd10, 0, 0, 0, 0,  0, 0, 0,  1, 3'd4, "R10 hash end read");
    acc(1, 3'd4, 4'd10, 1, 0, 0, 0,  1, 1, 0,  1, 3'd4, "R10 hash end write");
    idle(0, 3'd0, "R10 R11 freed after hash end");
    acc(1, 3'd3, 4'd5,  1, 0, 1, 1,  1, 1, 0,  0, 3'd0, "R7 request and release free");
    acc(1, 3'd3, 4'd0,  0, 0, 0, 0,  1, 0, 0,  1, 3'd3, "R7 granted loc 3");
    acc(1, 3'd3, 4'd9,  0, 0, 0, 0,  0, 0, 0,  1, 3'd3, "R10 hash data read");
    idle(1, 3'd3, "R11 owner stable");

    @(negedge clk);
    @(negedge clk);
    #(CLK_PERIOD/2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule